// File: doc/BRIEF.md
# Compare-Match Toggling Timer/Counter

This block is an 8-bit up-counter that advances on a strobe from a clock prescaler. The strobe is chosen from several prescaled strobes by a select field. The running count is compared with a reference value that software writes but cannot read back. When the count equals the reference on an active strobe, three things happen:

- the output latch inverts;
- a sticky interrupt request flag is set;
- the counter restarts from zero.

Software can therefore get a programmable interval from the interrupt flag, or a divided clock or square wave from the latch.

The latch feeds two consumers. The first is a pin output, gated by an output-enable flag. The second is an internal tap for a serial-clock selector, and this tap is never gated. A mode register holds the run enable, the strobe select and a one-shot clear command. The clear zeroes the counter, the latch and the interrupt flag together. The whole block runs on one system clock, and the prescaled strobes are one-cycle enables in that clock domain.

Top module: `cmp_toggle_timer`

## Requirements
- R1: After reset the reference holds 0xFF, and run enable, strobe select, output-enable bits, count, latch and interrupt flag are all 0. With strobes on every cycle after enabling, the first latch inversion therefore comes on the 256th counted strobe.
- R2: While enabled, the counter advances only on cycles where `tick_i[sel]` is 1. Here `sel` is mode bits 1:0 at address 1. Strobes on the other lines have no effect.
- R3: On a counted strobe with count equal to the reference, the latch inverts, the interrupt flag sets and the count returns to 0. For a reference of N, successive inversions are therefore N+1 counted strobes apart.
- R4: Once set, the interrupt flag stays set, including when a further match occurs. It is cleared by a write to address 3 with bit 0 equal to 0, or by the mode clear. A match in the same cycle as the software clear leaves the flag set.
- R5: `tc_pin_o` follows the latch when output-enable bit 2 of address 2 is 1, and is 0 otherwise.
- R6: `sck_tap_o` follows the latch whatever the output-enable bits hold.
- R7: A write to address 1 with bit 3 and bit 2 both 1 zeroes the count, the latch and the interrupt flag at that edge, overriding any strobe in that cycle. Counting then resumes on the next counted strobe. Bit 3 is not stored and reads as 0. If bit 2 of the write is 0, the write only disables the timer.
- R8: While the enable bit is 0, the count and the latch hold their values whatever the strobes do.
- R9: `rdata_o` is combinational on `addr_i`:
  - address 0 reads 0, because the reference is write-only;
  - address 1 reads {5'b0, enable, select[1:0]};
  - address 2 reads {oe_timer1, oe_timer0, buzzer_enable, 1'b0};
  - address 3 reads {6'b0, latch, irq}.
  
  A write to address 0 loads the reference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | NSEL | One-cycle prescaled count strobes, one per select value |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for write and read |
| wdata_i | input | W | Write data |
| rdata_o | output | W | Combinational read data for `addr_i` |
| tc_pin_o | output | 1 | Latch gated by the output-enable flag |
| sck_tap_o | output | 1 | Ungated latch for the serial clock selector |
| irq_o | output | 1 | Sticky interrupt request flag |

## Verification
A write or a strobe presented in a cycle takes effect at the next rising edge. The latch, the interrupt flag and both latch outputs therefore change exactly one edge after the stimulus, and the read data reflects the new state in that same cycle. The bench drives inputs on the falling edge and steps a reference model of the requirements once per cycle. It compares every output one time unit after the rising edge, so each result is checked in the cycle it is due and never a cycle early or late.

// File: rtl/cmp_toggle_timer.sv
module cmp_toggle_timer #(
  parameter int W    = 8,
  parameter int NSEL = 4,
  localparam int SW  = $clog2(NSEL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSEL-1:0] tick_i,
  input  logic            wr_i,
  input  logic [1:0]      addr_i,
  input  logic [W-1:0]    wdata_i,
  output logic [W-1:0]    rdata_o,
  output logic            tc_pin_o,
  output logic            sck_tap_o,
  output logic            irq_o
);

  logic [W-1:0]  ref_q, cnt_q;
  logic          en_q, lat_q, irq_q;
  logic [SW-1:0] sel_q;
  logic [3:1]    oe_q;

  wire wr_ref  = wr_i && addr_i == 2'd0;
  wire wr_mode = wr_i && addr_i == 2'd1;
  wire wr_oe   = wr_i && addr_i == 2'd2;
  wire wr_st   = wr_i && addr_i == 2'd3;
  wire clr     = wr_mode && wdata_i[3] && wdata_i[2];
  wire step    = en_q && tick_i[sel_q];
  wire hit     = step && cnt_q == ref_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '1;
      en_q  <= 1'b0;
      sel_q <= '0;
      oe_q  <= '0;
    end else begin
      if (wr_ref)  ref_q <= wdata_i;
      if (wr_mode) begin
        en_q  <= wdata_i[2];
        sel_q <= wdata_i[SW-1:0];
      end
      if (wr_oe)   oe_q <= wdata_i[3:1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lat_q <= 1'b0;
      irq_q <= 1'b0;
    end else if (clr) begin
      cnt_q <= '0;
      lat_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (hit) begin
        cnt_q <= '0;
        lat_q <= ~lat_q;
        irq_q <= 1'b1;
      end else begin
        if (step) cnt_q <= cnt_q + 1'b1;
        if (wr_st && !wdata_i[0]) irq_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      2'd1:    rdata_o[2:0] = {en_q, sel_q};
      2'd2:    rdata_o[3:0] = {oe_q, 1'b0};
      2'd3:    rdata_o[1:0] = {lat_q, irq_q};
      default: rdata_o = '0;
    endcase
  end

  assign tc_pin_o  = lat_q & oe_q[2];
  assign sck_tap_o = lat_q;
  assign irq_o     = irq_q;

  // R3
  match_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !clr) |=> (lat_q != $past(lat_q)) && irq_q && cnt_q == '0);

  // R7
  mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0 && !lat_q && !irq_q);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !clr) |=> $stable(lat_q) && $stable(cnt_q));

  // R4
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !clr && !(wr_st && !wdata_i[0])) |=> irq_q);

  // R2
  no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !tick_i[sel_q] && !clr) |=> $stable(cnt_q) && $stable(lat_q));

endmodule

// File: tb/cmp_toggle_timer_test.sv
`timescale 1ns/1ps
module cmp_toggle_timer_test;
  localparam int W = 8;
  localparam int NSEL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSEL-1:0] tick_i = '0;
  logic wr_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [W-1:0] wdata_i = '0;
  logic [W-1:0] rdata_o;
  logic tc_pin_o, sck_tap_o, irq_o;

  always #2.5 clk = ~clk;

  cmp_toggle_timer #(.W(W), .NSEL(NSEL)) uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .tc_pin_o(tc_pin_o),
    .sck_tap_o(sck_tap_o), .irq_o(irq_o));

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [W-1:0] m_ref = 8'hFF, m_cnt = '0;
  logic m_en = 0, m_lat = 0, m_irq = 0;
  logic [1:0] m_sel = '0;
  logic [3:1] m_oe = '0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] model_rd(input logic [1:0] a);
    case (a)
      2'd1:    return {5'b0, m_en, m_sel};
      2'd2:    return {4'b0, m_oe, 1'b0};
      2'd3:    return {6'b0, m_lat, m_irq};
      default: return '0;
    endcase
  endfunction

  task automatic model_step(input logic [NSEL-1:0] t, input logic w,
                            input logic [1:0] a, input logic [W-1:0] d);
    logic clr, step, hit;
    clr  = w && a == 2'd1 && d[3] && d[2];
    step = m_en && t[m_sel];
    hit  = step && m_cnt == m_ref;
    if (w && a == 2'd0) m_ref = d;
    if (w && a == 2'd1) begin m_en = d[2]; m_sel = d[1:0]; end
    if (w && a == 2'd2) m_oe = d[3:1];
    if (clr) begin
      m_cnt = '0; m_lat = 0; m_irq = 0;
    end else if (hit) begin
      m_cnt = '0; m_lat = ~m_lat; m_irq = 1;
    end else begin
      if (step) m_cnt = m_cnt + 1'b1;
      if (w && a == 2'd3 && !d[0]) m_irq = 0;
    end
  endtask

  task automatic cyc(input logic [NSEL-1:0] t, input logic w,
                     input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    tick_i = t; wr_i = w; addr_i = a; wdata_i = d;
    model_step(t, w, a, d);
    @(posedge clk);
    #1;
    wr_i = 0;
    chk("R5 pin", tc_pin_o, m_lat & m_oe[2]);
    chk("R6 tap", sck_tap_o, m_lat);
    chk("R4 irq", irq_o, m_irq);
    chk("R9 rdata", rdata_o, model_rd(addr_i));
  endtask

  task automatic rd(input logic [1:0] a);
    cyc('0, 0, a, '0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1;
    // R1 reset state
    chk("R1 irq", irq_o, 0);
    chk("R1 tap", sck_tap_o, 0);
    chk("R1 pin", tc_pin_o, 0);
    rd(2'd1); chk("R1 mode", rdata_o, 0);
    rd(2'd2); chk("R1 oe", rdata_o, 0);
    rd(2'd0); chk("R9 ref write-only", rdata_o, 0);

    // R1: reference 0xFF gives first toggle on 256th strobe
    cyc('0, 1, 2'd1, 8'h04);
    for (int i = 0; i < 255; i++) cyc('1, 0, 2'd3, '0);
    chk("R1 no toggle before 256", sck_tap_o, 0);
    cyc('1, 0, 2'd3, '0);
    chk("R1 toggle at 256", sck_tap_o, 1);
    chk("R3 irq on match", irq_o, 1);

    // R5 / R6 gating
    chk("R5 pin gated", tc_pin_o, 0);
    chk("R6 tap ungated", sck_tap_o, 1);
    cyc('0, 1, 2'd2, 8'h04);
    chk("R5 pin enabled", tc_pin_o, 1);

    // R4 sticky and clear
    cyc('0, 1, 2'd3, 8'h01);
    chk("R4 write 1 keeps", irq_o, 1);
    cyc('0, 1, 2'd3, 8'h00);
    chk("R4 write 0 clears", irq_o, 0);

    // R3 period with ref 2
    cyc('0, 1, 2'd0, 8'h02);
    cyc('0, 1, 2'd1, 8'h0C);
    chk("R7 clear latch", sck_tap_o, 0);
    rd(2'd1); chk("R7 bit3 reads 0", rdata_o, 8'h04);
    cyc('1, 0, 2'd3, '0);
    cyc('1, 0, 2'd3, '0);
    chk("R3 no toggle at 2 ticks", sck_tap_o, 0);
    cyc('1, 0, 2'd3, '0);
    chk("R3 toggle at ref+1", sck_tap_o, 1);

    // R2 unselected strobes ignored
    cyc('0, 1, 2'd0, 8'h00);
    cyc('0, 1, 2'd1, 8'h06);
    for (int i = 0; i < 5; i++) cyc(4'b1011, 0, 2'd3, '0);
    chk("R2 other strobes ignored", sck_tap_o, 1);
    cyc(4'b0100, 0, 2'd3, '0);
    chk("R2 selected strobe counts", sck_tap_o, 0);

    // R8 disabled holds
    cyc('1, 0, 2'd3, '0);
    cyc('0, 1, 2'd1, 8'h08);
    for (int i = 0; i < 10; i++) cyc('1, 0, 2'd3, '0);
    chk("R8 latch held", sck_tap_o, 1);

    // R4 match wins over software clear
    cyc('0, 1, 2'd1, 8'h04);
    cyc('1, 1, 2'd3, 8'h00);
    chk("R4 match beats clear", irq_o, 1);

    // random phase
    for (int i = 0; i < 20000; i++) begin
      logic [NSEL-1:0] t;
      logic w;
      logic [1:0] a;
      logic [W-1:0] d;
      t = NSEL'($urandom);
      w = ($urandom % 8) == 0;
      a = 2'($urandom);
      d = 8'($urandom);
      if (a == 2'd0) d = 8'($urandom % 8);
      if (a == 2'd1 && ($urandom % 4) != 0) d[2] = 1'b1;
      cyc(t, w, a, d);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule